// File: doc/BRIEF.md
# DMA Event and Interrupt Router

This block sits beside the thread sequencers of a programmable DMA engine and decides where each "send event" goes. Any of the channel threads or the manager thread may raise a send strobe with an event number. For each event number, one routing bit chooses the path. With the bit clear, the event is posted as a pending flag that the threads can poll and later consume. With the bit set, the event raises a level interrupt line toward the host processors instead.

Interrupt lines are sticky. Software lowers them through a write-one-to-clear register and can read them back through a status register. A separate fault output reports whether any of the engine's fault sources is active. It follows those sources and needs no software clear.

Software reaches the block through a simple register port. Address 0 holds the routing register, which can be read and written. Address 1 is the clear register, which can only be written and always reads as zero. Address 2 is the interrupt status, which can only be read. Address 3 reads as zero.

Top module: `evr_router`

## Requirements
- R1: After reset the routing register reads 0, every irq and pending bit is low, and the fault output is low.
- R2: A send for event N while routing bit N is 1 sets irq[N] on the next clock edge and leaves evt_pend[N] unchanged; routing uses the routing value held before that edge.
- R3: A send for event N while routing bit N is 0 sets evt_pend[N] on the next clock edge and leaves irq[N] unchanged.
- R4: irq[N] stays high until a write to address 1 with data bit N = 1 lowers it on the next edge; data bits written as 0 leave their irq bits unchanged.
- R5: When a send that sets irq[N] and a clear of bit N fall in the same cycle, irq[N] ends high.
- R6: evt_pend[N] stays high until an ack strobe with index N lowers it on the next edge; repeated sends for N while pending add nothing, so one ack clears it; a send and an ack for the same N in the same cycle leave it high.
- R7: Sends from several threads in the same cycle are all routed, each by its own index.
- R8: irq_fault is the OR of all fault_src bits, delayed by FAULT_STAGES edges (1 by default), and falls once every source drops.
- R9: Reads are combinational: address 0 returns the routing register, address 1 returns 0, address 2 returns the irq vector; writes to address 2 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 routing, 1 clear, 2 status) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Read data |
| sev_vld | input | 9 | Per-thread send strobe (bit 8 is the manager) |
| sev_idx | input | 45 | Per-thread event index, 5 bits each, thread t at [5t+4:5t] |
| ack_vld | input | 1 | Consume strobe from a thread |
| ack_idx | input | 5 | Event index being consumed |
| fault_src | input | 4 | Fault sources |
| evt_pend | output | 32 | Pending internal events |
| irq | output | 32 | Level interrupt lines, active high |
| irq_fault | output | 1 | Fault interrupt, active high |

## Verification
A wrong routing bit sends an event down the other path. The mistake shows one edge after the send as a missing irq bit paired with a stray pending bit, or the reverse. A stuck or wrongly cleared state flop shows up later. It appears as an irq or pending bit that outlives its clear or ack, or falls without one, and the status read at address 2 shows the same error in the same cycle. Fault path errors show as a fault output that does not track the OR of the sources after the configured delay.

// File: rtl/evr_pkg.sv
package evr_pkg;
   typedef enum logic [1:0] {
      REG_ROUTE  = 2'd0,
      REG_CLEAR  = 2'd1,
      REG_STATUS = 2'd2,
      REG_RSVD   = 2'd3
   } evr_reg_e;
endpackage

// File: rtl/evr_idx_decode.sv
module evr_idx_decode #(
   parameter int NUM_SRC = 9,
   parameter int NUM_EVT = 32,
   parameter int IDX_W   = 5
) (
   input  logic [NUM_SRC-1:0]       vld,
   input  logic [NUM_SRC*IDX_W-1:0] idx,
   output logic [NUM_EVT-1:0]       hit
);
   always_comb begin
      hit = '0;
      for (int s = 0; s < NUM_SRC; s++) begin
         for (int e = 0; e < NUM_EVT; e++) begin
            if (vld[s] && (idx[s*IDX_W +: IDX_W] == IDX_W'(e)))
               hit[e] = 1'b1;
         end
      end
   end
endmodule

// File: rtl/evr_regs.sv
module evr_regs
   import evr_pkg::*;
#(
   parameter int NUM_EVT = 32,
   parameter int DATA_W  = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [1:0]         wr_addr,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic [1:0]         rd_addr,
   input  logic [NUM_EVT-1:0] irq_vec,
   output logic [NUM_EVT-1:0] route_q,
   output logic [NUM_EVT-1:0] clr_mask,
   output logic [DATA_W-1:0]  rd_data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         route_q <= '0;
      else if (wr_en && (wr_addr == REG_ROUTE))
         route_q <= wr_data[NUM_EVT-1:0];
   end

   assign clr_mask = (wr_en && (wr_addr == REG_CLEAR)) ? wr_data[NUM_EVT-1:0] : '0;

   always_comb begin
      rd_data = '0;
      case (evr_reg_e'(rd_addr))
         REG_ROUTE:  rd_data[NUM_EVT-1:0] = route_q;
         REG_STATUS: rd_data[NUM_EVT-1:0] = irq_vec;
         default:    rd_data = '0;
      endcase
   end
endmodule

// File: rtl/evr_lines.sv
module evr_lines #(
   parameter int NUM_EVT = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EVT-1:0] sev_hit,
   input  logic [NUM_EVT-1:0] route,
   input  logic [NUM_EVT-1:0] clr_mask,
   input  logic [NUM_EVT-1:0] ack_hit,
   output logic [NUM_EVT-1:0] irq,
   output logic [NUM_EVT-1:0] evt_pend
);
   for (genvar n = 0; n < NUM_EVT; n++) begin : g_line
      logic irq_r;
      logic pend_r;
      logic to_irq;
      logic to_thr;

      assign to_irq = sev_hit[n] & route[n];
      assign to_thr = sev_hit[n] & ~route[n];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            irq_r  <= 1'b0;
            pend_r <= 1'b0;
         end else begin
            if (to_irq)
               irq_r <= 1'b1;
            else if (clr_mask[n])
               irq_r <= 1'b0;
            if (to_thr)
               pend_r <= 1'b1;
            else if (ack_hit[n])
               pend_r <= 1'b0;
         end
      end

      assign irq[n]      = irq_r;
      assign evt_pend[n] = pend_r;
   end
endmodule

// File: rtl/evr_fault.sv
module evr_fault #(
   parameter int FAULT_W      = 4,
   parameter int FAULT_STAGES = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [FAULT_W-1:0] fault_src,
   output logic               irq_fault
);
   logic any_fault;
   assign any_fault = |fault_src;

   if (FAULT_STAGES == 1) begin : g_one
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= 1'b0;
         else        q <= any_fault;
      end
      assign irq_fault = q;
   end else begin : g_two
      logic [1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= '0;
         else        q <= {q[0], any_fault};
      end
      assign irq_fault = q[1];
   end
endmodule

// File: rtl/evr_router.sv
module evr_router #(
   parameter int NUM_THR      = 9,
   parameter int NUM_EVT      = 32,
   parameter int DATA_W       = 32,
   parameter int FAULT_W      = 4,
   parameter int FAULT_STAGES = 1,
   localparam int IDX_W       = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [1:0]               wr_addr,
   input  logic [DATA_W-1:0]        wr_data,
   input  logic [1:0]               rd_addr,
   output logic [DATA_W-1:0]        rd_data,
   input  logic [NUM_THR-1:0]       sev_vld,
   input  logic [NUM_THR*IDX_W-1:0] sev_idx,
   input  logic                     ack_vld,
   input  logic [IDX_W-1:0]         ack_idx,
   input  logic [FAULT_W-1:0]       fault_src,
   output logic [NUM_EVT-1:0]       evt_pend,
   output logic [NUM_EVT-1:0]       irq,
   output logic                     irq_fault
);
   if (NUM_EVT < 1 || NUM_EVT > DATA_W) begin : g_bad_evt
      $error("evr_router: NUM_EVT must be in 1..DATA_W");
   end
   if (NUM_THR < 1) begin : g_bad_thr
      $error("evr_router: NUM_THR must be at least 1");
   end
   if (FAULT_W < 1) begin : g_bad_flt
      $error("evr_router: FAULT_W must be at least 1");
   end
   if (FAULT_STAGES != 1 && FAULT_STAGES != 2) begin : g_bad_stg
      $error("evr_router: FAULT_STAGES must be 1 or 2");
   end

   logic [NUM_EVT-1:0] route_q;
   logic [NUM_EVT-1:0] clr_mask;
   logic [NUM_EVT-1:0] sev_hit;
   logic [NUM_EVT-1:0] ack_hit;

   evr_idx_decode #(.NUM_SRC(NUM_THR), .NUM_EVT(NUM_EVT), .IDX_W(IDX_W)) u_sev_dec (
      .vld (sev_vld),
      .idx (sev_idx),
      .hit (sev_hit)
   );

   evr_idx_decode #(.NUM_SRC(1), .NUM_EVT(NUM_EVT), .IDX_W(IDX_W)) u_ack_dec (
      .vld (ack_vld),
      .idx (ack_idx),
      .hit (ack_hit)
   );

   evr_regs #(.NUM_EVT(NUM_EVT), .DATA_W(DATA_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .rd_addr  (rd_addr),
      .irq_vec  (irq),
      .route_q  (route_q),
      .clr_mask (clr_mask),
      .rd_data  (rd_data)
   );

   evr_lines #(.NUM_EVT(NUM_EVT)) u_lines (
      .clk      (clk),
      .rst_n    (rst_n),
      .sev_hit  (sev_hit),
      .route    (route_q),
      .clr_mask (clr_mask),
      .ack_hit  (ack_hit),
      .irq      (irq),
      .evt_pend (evt_pend)
   );

   evr_fault #(.FAULT_W(FAULT_W), .FAULT_STAGES(FAULT_STAGES)) u_fault (
      .clk       (clk),
      .rst_n     (rst_n),
      .fault_src (fault_src),
      .irq_fault (irq_fault)
   );
endmodule

// File: rtl/evr_router_chk.sv
module evr_router_chk
   import evr_pkg::*;
#(
   parameter int NUM_EVT      = 32,
   parameter int DATA_W       = 32,
   parameter int FAULT_W      = 4,
   parameter int FAULT_STAGES = 1
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_EVT-1:0] route_q,
   input logic [NUM_EVT-1:0] sev_hit,
   input logic [NUM_EVT-1:0] clr_mask,
   input logic [NUM_EVT-1:0] ack_hit,
   input logic [NUM_EVT-1:0] irq,
   input logic [NUM_EVT-1:0] evt_pend,
   input logic [FAULT_W-1:0] fault_src,
   input logic               irq_fault,
   input logic [1:0]         rd_addr,
   input logic [DATA_W-1:0]  rd_data
);
   logic [1:0] age;
   logic       hist_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         age <= '0;
      else if (age != 2'd2) age <= age + 2'd1;
   end
   assign hist_ok = (age == 2'd2);

   p_irq_set_r2: assert property (@(posedge clk) disable iff (!rst_n || !hist_ok)
      ($past(sev_hit & route_q) & ~irq) == '0);

   p_irq_cause_r4: assert property (@(posedge clk) disable iff (!rst_n || !hist_ok)
      ((irq & ~$past(irq)) & ~$past(sev_hit & route_q)) == '0);

   p_irq_fall_r4: assert property (@(posedge clk) disable iff (!rst_n || !hist_ok)
      (($past(irq) & ~irq) & ~$past(clr_mask)) == '0);

   p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n || !hist_ok)
      ($past(sev_hit & route_q & clr_mask) & ~irq) == '0);

   p_pend_cause_r3: assert property (@(posedge clk) disable iff (!rst_n || !hist_ok)
      ((evt_pend & ~$past(evt_pend)) & ~$past(sev_hit & ~route_q)) == '0);

   p_pend_fall_r6: assert property (@(posedge clk) disable iff (!rst_n || !hist_ok)
      (($past(evt_pend) & ~evt_pend) & ~$past(ack_hit)) == '0);

   if (FAULT_STAGES == 1) begin : g_f1
      p_fault_track_r8: assert property (@(posedge clk) disable iff (!rst_n || !hist_ok)
         irq_fault == $past(|fault_src));
   end else begin : g_f2
      p_fault_track_r8: assert property (@(posedge clk) disable iff (!rst_n || !hist_ok)
         irq_fault == $past(|fault_src, 2));
   end

   p_clr_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == REG_CLEAR) |-> (rd_data == '0));

   p_status_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == REG_STATUS) |-> (rd_data[NUM_EVT-1:0] == irq));
endmodule

bind evr_router evr_router_chk #(
   .NUM_EVT      (NUM_EVT),
   .DATA_W       (DATA_W),
   .FAULT_W      (FAULT_W),
   .FAULT_STAGES (FAULT_STAGES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .route_q   (route_q),
   .sev_hit   (sev_hit),
   .clr_mask  (clr_mask),
   .ack_hit   (ack_hit),
   .irq       (irq),
   .evt_pend  (evt_pend),
   .fault_src (fault_src),
   .irq_fault (irq_fault),
   .rd_addr   (rd_addr),
   .rd_data   (rd_data)
);

// File: tb/sim_evr_router.sv
`timescale 1ns/1ps
module sim_evr_router;
   localparam int NT = 9;
   localparam int NE = 32;
   localparam int IW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [1:0]    wr_addr = '0;
   logic [31:0]   wr_data = '0;
   logic [1:0]    rd_addr = '0;
   logic [31:0]   rd_data;
   logic [NT-1:0] sev_vld = '0;
   logic [NT*IW-1:0] sev_idx = '0;
   logic          ack_vld = 1'b0;
   logic [IW-1:0] ack_idx = '0;
   logic [3:0]    fault_src = '0;
   logic [NE-1:0] evt_pend;
   logic [NE-1:0] irq;
   logic          irq_fault;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   evr_router u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .sev_vld(sev_vld), .sev_idx(sev_idx),
      .ack_vld(ack_vld), .ack_idx(ack_idx), .fault_src(fault_src),
      .evt_pend(evt_pend), .irq(irq), .irq_fault(irq_fault)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic send(input int thr, input int idx);
      sev_vld[thr] = 1'b1;
      sev_idx[thr*IW +: IW] = IW'(idx);
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
   endtask

   task automatic tick();
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0; sev_vld = '0; ack_vld = 1'b0;
   endtask

   task automatic read_chk(input string req, input logic [1:0] a, input logic [31:0] exp);
      rd_addr = a;
      #1;
      check(req, rd_data, exp);
   endtask

   task automatic t_reset();
      check("R1 irq", irq, 32'h0);
      check("R1 evt_pend", evt_pend, 32'h0);
      check("R1 irq_fault", {31'b0, irq_fault}, 32'h0);
      read_chk("R1 route reg", 2'd0, 32'h0);
   endtask

   task automatic t_route_irq();
      wr(2'd0, 32'h0000_0011);
      send(2, 4);
      tick();
      check("R2 send in write cycle uses old routing", evt_pend, 32'h0000_0010);
      check("R2 irq unchanged by old routing", irq, 32'h0);
      ack_vld = 1'b1; ack_idx = 5'd4;
      tick();
      send(2, 4);
      tick();
      check("R2 irq set", irq, 32'h0000_0010);
      check("R2 pend untouched", evt_pend, 32'h0);
      wr(2'd2, 32'hFFFF_FFFF);
      tick();
      read_chk("R9 status write ignored", 2'd2, 32'h0000_0010);
      read_chk("R9 route readback", 2'd0, 32'h0000_0011);
      read_chk("R9 clear reads zero", 2'd1, 32'h0);
      read_chk("R9 reserved reads zero", 2'd3, 32'h0);
   endtask

   task automatic t_route_evt();
      send(8, 7);
      tick();
      check("R3 pend set", evt_pend, 32'h0000_0080);
      check("R3 irq unchanged", irq, 32'h0000_0010);
      send(1, 7);
      tick();
      check("R6 repeat send no extra", evt_pend, 32'h0000_0080);
      ack_vld = 1'b1; ack_idx = 5'd7;
      tick();
      check("R6 one ack clears", evt_pend, 32'h0);
   endtask

   task automatic t_clear();
      tick(); tick();
      check("R4 irq holds", irq, 32'h0000_0010);
      wr(2'd1, 32'hFFFF_FFEF);
      tick();
      check("R4 zero bits keep irq", irq, 32'h0000_0010);
      wr(2'd1, 32'h0000_0010);
      tick();
      check("R4 clear lowers irq", irq, 32'h0);
      read_chk("R4 status after clear", 2'd2, 32'h0);
   endtask

   task automatic t_set_vs_clr();
      send(0, 4);
      wr(2'd1, 32'h0000_0010);
      tick();
      check("R5 set beats clear", irq, 32'h0000_0010);
      wr(2'd1, 32'h0000_0010);
      tick();
      check("R5 later clear", irq, 32'h0);
   endtask

   task automatic t_multi();
      send(0, 0);
      send(3, 9);
      send(5, 31);
      tick();
      check("R7 irq from thread 0", irq, 32'h0000_0001);
      check("R7 pend from threads 3,5", evt_pend, 32'h8000_0200);
      send(6, 9);
      ack_vld = 1'b1; ack_idx = 5'd9;
      tick();
      check("R6 send beats ack", evt_pend, 32'h8000_0200);
      ack_vld = 1'b1; ack_idx = 5'd31;
      tick();
      check("R6 ack clears only its bit", evt_pend, 32'h0000_0200);
      wr(2'd0, 32'h0000_0000);
      tick();
      check("R2 routing change keeps irq", irq, 32'h0000_0001);
      send(4, 0);
      tick();
      check("R3 rerouted event to threads", evt_pend, 32'h0000_0201);
      check("R3 irq unchanged after reroute", irq, 32'h0000_0001);
   endtask

   task automatic t_fault();
      fault_src = 4'b0100;
      #1;
      check("R8 no combinational path", {31'b0, irq_fault}, 32'h0);
      tick();
      check("R8 fault rises", {31'b0, irq_fault}, 32'h1);
      fault_src = 4'b1001;
      tick();
      check("R8 fault holds", {31'b0, irq_fault}, 32'h1);
      wr(2'd1, 32'hFFFF_FFFF);
      tick();
      check("R8 clear reg does not drop fault", {31'b0, irq_fault}, 32'h1);
      check("R4 full clear", irq, 32'h0);
      fault_src = 4'b0000;
      tick();
      check("R8 fault falls", {31'b0, irq_fault}, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_route_irq();
      t_route_evt();
      t_clear();
      t_set_vs_clr();
      t_multi();
      t_fault();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog (all requirements): actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule